// File: doc/BRIEF.md
# Voice Group Block Sequencer

This block turns a request for one voice group into an ordered stream of memory-block numbers for a downstream playback engine. Each group is an ordered list of entries held in one entry pool that all groups share. An entry names one of the stored memory blocks. A block may appear in any number of groups, and it may appear several times in one group, including twice in a row. Each group is described by a start index into the pool and an entry count. Both tables are computed when the design is elaborated, so no load port is needed.

After a start command, the sequencer offers the first block number. It holds that number until the engine reports that the block has finished. It then leaves a one-cycle gap, so that a repeated block is visibly presented again, and offers the next entry. After the last entry completes, it raises a one-cycle group-complete pulse. An abort input stops the walk at any time, and no completion pulse follows it. A busy flag spans the whole run.

Top module: `voice_group_seq`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `blk_valid_o`, `blk_id_o`, `busy_o` and `grp_done_o` are all zero.
- R2: A start is taken when `start_i` is sampled high while idle, `abort_i` is low and `group_i` is below 30. In the cycle after a start of a group with a nonzero count, `busy_o` and `blk_valid_o` are 1 and `blk_id_o` holds the group's first entry.
- R3: While `blk_valid_o` is 1 and `blk_done_i` has not been sampled high, `blk_id_o` stays unchanged and `blk_valid_o` stays 1.
- R4: `blk_done_i` is sampled high while a block is offered and that block is not the group's last. In the next cycle `blk_valid_o` is 0 and `busy_o` is 1. In the cycle after that, the next pool entry is offered. Entries are offered in pool order, and repeated block numbers are offered again.
- R5: `blk_done_i` is sampled high on the group's last entry. In the next cycle `grp_done_o` and `busy_o` are 1 and `blk_valid_o` is 0. In the cycle after that, all three are 0, so `grp_done_o` is a single-cycle pulse.
- R6: A start of a group with a zero count produces no block offer. In the cycle after the start, `grp_done_o` and `busy_o` are both 1 for one cycle.
- R7: `abort_i` sampled high while busy sets all outputs to zero in the next cycle, and `grp_done_o` is never raised for that run. Abort takes priority over a simultaneous `blk_done_i`. A start sampled together with abort is not taken.
- R8: The block ignores three kinds of stimulus. A start while busy leaves the running sequence and its current block number unchanged. A start with `group_i` of 30 or 31 leaves the block idle. `blk_done_i` while no block is offered has no effect.
- R9: The default tables are as follows. Group g (0 to 29) has g mod 5 entries. Its start index is the sum of the entry counts of groups 0 to g-1. Pool entry i holds block floor(i/2) mod 254. Block numbers are 8 bits wide and pool capacity is 896 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request for the group on `group_i` |
| group_i | input | 5 | Group number, 0 to 29 valid |
| abort_i | input | 1 | Stop the running sequence without completion |
| blk_done_i | input | 1 | Playback engine reports the offered block finished |
| blk_valid_o | output | 1 | A block number is being offered |
| blk_id_o | output | 8 | Offered memory-block number, zero when not valid |
| busy_o | output | 1 | A group run is in progress, including its completion cycle |
| grp_done_o | output | 1 | One-cycle pulse after the last entry completes |

## Verification
Every result is due exactly one clock edge after the input that causes it, because all of the state passes through a single state register. A start produces its first block offer one edge later. A done produces the gap, or the completion pulse, one edge later, and the next offer comes one edge after the gap. An abort produces idle outputs one edge later. The bench drives inputs and samples outputs 1 ns after each rising edge, so each check reads the state produced by the edge that sampled the previous stimulus. Expected block numbers come from the R9 table formulas, evaluated in the bench from a vector of group, start index and count.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SHOW = 2'd1,
    ST_GAP  = 2'd2,
    ST_FIN  = 2'd3
  } vgs_state_e;

  // entry count of group g
  function automatic int grp_count(input int g, input int modv);
    return g % modv;
  endfunction

  // first pool index of group g: groups packed back to back
  function automatic int grp_base(input int g, input int modv);
    int acc;
    acc = 0;
    for (int h = 0; h < g; h++) acc += h % modv;
    return acc;
  endfunction

  // block number stored at pool index i
  function automatic int pool_block(input int i, input int nblk);
    return (i / 2) % nblk;
  endfunction

endpackage

// File: rtl/vgs_group_table.sv
module vgs_group_table
  import vgs_pkg::*;
#(
  parameter int NUM_GROUPS = 30,
  parameter int COUNT_MOD  = 5,
  parameter int GRP_W      = 5,
  parameter int IDX_W      = 10,
  parameter int LEN_W      = 10
) (
  input  logic [GRP_W-1:0] grp_i,
  output logic             known_o,
  output logic [IDX_W-1:0] base_o,
  output logic [LEN_W-1:0] count_o
);

  logic [IDX_W-1:0] base_tab  [NUM_GROUPS];
  logic [LEN_W-1:0] count_tab [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_desc
    assign base_tab[g]  = IDX_W'(grp_base(g, COUNT_MOD));
    assign count_tab[g] = LEN_W'(grp_count(g, COUNT_MOD));
  end

  always_comb begin
    known_o = (int'(grp_i) < NUM_GROUPS);
    base_o  = '0;
    count_o = '0;
    if (known_o) begin
      base_o  = base_tab[grp_i];
      count_o = count_tab[grp_i];
    end
  end

endmodule

// File: rtl/vgs_entry_pool.sv
module vgs_entry_pool
  import vgs_pkg::*;
#(
  parameter int POOL_DEPTH = 896,
  parameter int NUM_BLOCKS = 254,
  parameter int BLK_W      = 8,
  parameter int IDX_W      = 10
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [BLK_W-1:0] blk_o
);

  logic [BLK_W-1:0] pool [POOL_DEPTH];

  for (genvar i = 0; i < POOL_DEPTH; i++) begin : g_pool
    assign pool[i] = BLK_W'(pool_block(i, NUM_BLOCKS));
  end

  always_comb begin
    blk_o = '0;
    if (int'(idx_i) < POOL_DEPTH) blk_o = pool[idx_i];
  end

endmodule

// File: rtl/vgs_walker.sv
module vgs_walker
  import vgs_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             known_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [LEN_W-1:0] count_i,
  input  logic             abort_i,
  input  logic             done_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             fin_o
);

  vgs_state_e       state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             pos_en;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    left_d  = left_q;
    pos_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && !abort_i && known_i) begin
          pos_en  = 1'b1;
          ptr_d   = base_i;
          left_d  = count_i;
          state_d = (count_i == '0) ? ST_FIN : ST_SHOW;
        end
      end
      ST_SHOW: begin
        if (abort_i) begin
          state_d = ST_IDLE;
        end else if (done_i) begin
          if (left_q == LEN_W'(1)) begin
            state_d = ST_FIN;
          end else begin
            pos_en  = 1'b1;
            ptr_d   = ptr_q + IDX_W'(1);
            left_d  = left_q - LEN_W'(1);
            state_d = ST_GAP;
          end
        end
      end
      ST_GAP:  state_d = abort_i ? ST_IDLE : ST_SHOW;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      if (pos_en) begin
        ptr_q  <= ptr_d;
        left_q <= left_d;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign valid_o = (state_q == ST_SHOW);
  assign busy_o  = (state_q != ST_IDLE);
  assign fin_o   = (state_q == ST_FIN);

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !done_i && !abort_i |=> valid_o && $stable(ptr_o)); // R3
  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && done_i && !abort_i |=> !valid_o && busy_o); // R4
  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o && !busy_o); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !fin_o && abort_i |=> !busy_o && !fin_o && !valid_o); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && start_i && !done_i && !abort_i |=> $stable(ptr_o)); // R8

endmodule

// File: rtl/voice_group_seq.sv
module voice_group_seq
  import vgs_pkg::*;
#(
  parameter int NUM_GROUPS = 30,
  parameter int NUM_BLOCKS = 254,
  parameter int POOL_DEPTH = 896,
  parameter int COUNT_MOD  = 5,
  parameter int BLK_W      = 8,
  localparam int GRP_W     = $clog2(NUM_GROUPS),
  localparam int IDX_W     = $clog2(POOL_DEPTH),
  localparam int LEN_W     = $clog2(POOL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [GRP_W-1:0] group_i,
  input  logic             abort_i,
  input  logic             blk_done_i,
  output logic             blk_valid_o,
  output logic [BLK_W-1:0] blk_id_o,
  output logic             busy_o,
  output logic             grp_done_o
);

  logic             known;
  logic [IDX_W-1:0] base;
  logic [LEN_W-1:0] count;
  logic [IDX_W-1:0] ptr;
  logic [BLK_W-1:0] blk;
  logic             valid;

  vgs_group_table #(
    .NUM_GROUPS(NUM_GROUPS), .COUNT_MOD(COUNT_MOD),
    .GRP_W(GRP_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_table (
    .grp_i(group_i), .known_o(known), .base_o(base), .count_o(count)
  );

  vgs_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .known_i(known),
    .base_i(base), .count_i(count), .abort_i(abort_i), .done_i(blk_done_i),
    .ptr_o(ptr), .valid_o(valid), .busy_o(busy_o), .fin_o(grp_done_o)
  );

  vgs_entry_pool #(
    .POOL_DEPTH(POOL_DEPTH), .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W(BLK_W), .IDX_W(IDX_W)
  ) u_pool (
    .idx_i(ptr), .blk_o(blk)
  );

  assign blk_valid_o = valid;
  assign blk_id_o    = valid ? blk : '0;

  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid_o |-> busy_o && !grp_done_o); // R2
  AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> blk_id_o == '0 && !grp_done_o); // R1

endmodule

// File: tb/tb_voice_group_seq.sv
module tb_voice_group_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, abort_i, blk_done_i;
  logic [4:0] group_i;
  logic       blk_valid_o, busy_o, grp_done_o;
  logic [7:0] blk_id_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  voice_group_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .group_i(group_i),
    .abort_i(abort_i), .blk_done_i(blk_done_i), .blk_valid_o(blk_valid_o),
    .blk_id_o(blk_id_o), .busy_o(busy_o), .grp_done_o(grp_done_o)
  );

  // group, first pool index, entry count (from the R9 table rule)
  localparam int VEC_N = 7;
  localparam int V_GRP   [VEC_N] = '{1, 3, 4, 9, 29, 0, 5};
  localparam int V_BASE  [VEC_N] = '{0, 3, 6, 16, 56, 0, 10};
  localparam int V_COUNT [VEC_N] = '{1, 3, 4, 4, 4, 0, 0};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    start_i = 0; abort_i = 0; blk_done_i = 0; group_i = '0;
  endtask

  task automatic run_vec(input int grp, input int base, input int cnt);
    start_i = 1; group_i = 5'(grp);
    tick();
    start_i = 0;
    if (cnt == 0) begin
      chk("R6 done", int'(grp_done_o), 1);
      chk("R6 busy", int'(busy_o), 1);
      chk("R6 no offer", int'(blk_valid_o), 0);
      tick();
      chk("R6 pulse end", int'(grp_done_o), 0);
      chk("R6 busy end", int'(busy_o), 0);
      return;
    end
    chk("R2 valid", int'(blk_valid_o), 1);
    chk("R2 busy", int'(busy_o), 1);
    for (int k = 0; k < cnt; k++) begin
      chk("R4 id", int'(blk_id_o), ((base + k) / 2) % 254);
      if (k == 0) begin
        tick();
        chk("R3 held valid", int'(blk_valid_o), 1);
        chk("R3 held id", int'(blk_id_o), (base / 2) % 254);
      end
      blk_done_i = 1;
      tick();
      blk_done_i = 0;
      if (k < cnt - 1) begin
        chk("R4 gap valid", int'(blk_valid_o), 0);
        chk("R4 gap busy", int'(busy_o), 1);
        tick();
        chk("R4 next valid", int'(blk_valid_o), 1);
      end
    end
    chk("R5 done", int'(grp_done_o), 1);
    chk("R5 busy", int'(busy_o), 1);
    chk("R5 valid", int'(blk_valid_o), 0);
    tick();
    chk("R5 pulse end", int'(grp_done_o), 0);
    chk("R5 busy end", int'(busy_o), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    #20;
    chk("R1 valid in reset", int'(blk_valid_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    @(posedge clk); #1 rst_n = 1;
    tick();
    chk("R1 valid", int'(blk_valid_o), 0);
    chk("R1 id", int'(blk_id_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(grp_done_o), 0);

    // R9 table vectors
    for (int v = 0; v < VEC_N; v++) begin
      run_vec(V_GRP[v], V_BASE[v], V_COUNT[v]);
      tick();
    end

    // R7 abort together with done on second entry of group 4
    start_i = 1; group_i = 5'd4; tick(); start_i = 0;
    blk_done_i = 1; tick(); blk_done_i = 0;
    tick();
    chk("R7 pre-abort id", int'(blk_id_o), 3);
    abort_i = 1; blk_done_i = 1; tick(); abort_i = 0; blk_done_i = 0;
    chk("R7 valid", int'(blk_valid_o), 0);
    chk("R7 busy", int'(busy_o), 0);
    chk("R7 done", int'(grp_done_o), 0);
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R7 no late done", int'(grp_done_o), 0);
    end

    // R7 abort in gap cycle
    start_i = 1; group_i = 5'd9; tick(); start_i = 0;
    blk_done_i = 1; tick(); blk_done_i = 0;
    abort_i = 1; tick(); abort_i = 0;
    chk("R7 gap abort busy", int'(busy_o), 0);
    tick();
    chk("R7 gap abort valid", int'(blk_valid_o), 0);

    // R7 start with abort not taken
    start_i = 1; abort_i = 1; group_i = 5'd3; tick(); idle_inputs();
    chk("R7 start+abort", int'(busy_o), 0);

    // R8 start while busy ignored
    start_i = 1; group_i = 5'd3; tick();
    group_i = 5'd29; tick(); start_i = 0;
    chk("R8 busy start valid", int'(blk_valid_o), 1);
    chk("R8 busy start id", int'(blk_id_o), 1);
    abort_i = 1; tick(); abort_i = 0;

    // R8 out-of-range groups
    start_i = 1; group_i = 5'd30; tick(); start_i = 0;
    chk("R8 group 30", int'(busy_o), 0);
    start_i = 1; group_i = 5'd31; tick(); start_i = 0;
    chk("R8 group 31", int'(busy_o), 0);

    // R8 done while idle
    blk_done_i = 1; tick(); blk_done_i = 0;
    chk("R8 idle done busy", int'(busy_o), 0);
    chk("R8 idle done pulse", int'(grp_done_o), 0);
    run_vec(3, 3, 3);

    // R1 reset mid-run
    start_i = 1; group_i = 5'd4; tick(); start_i = 0;
    rst_n = 0; #2;
    chk("R1 async reset busy", int'(busy_o), 0);
    chk("R1 async reset valid", int'(blk_valid_o), 0);
    @(posedge clk); #1 rst_n = 1;
    tick();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule